// File: doc/BRIEF.md
# Supply Low-Voltage Warning Register

This block is the 8-bit control and status register of a supply-voltage supervisor. An external comparator tells it, asynchronously, whether the supply has dropped below the warning threshold. The block turns a fresh drop into a sticky warning flag. Software clears the flag with an acknowledge write, which works only once the supply has recovered. The block drives the trip-point selects of the external warning and detect comparators, and raises an interrupt request when the flag and its enable are both set.

Three reset sources act on the register. A power-up reset clears every field. A low-voltage reset and any other system reset both act as warm resets: they clear the flag and the interrupt enable but keep the two trip-point selects. Software reads and writes the register through a small bus with a chip select, a write enable and byte-wide data.

Top module: `supply_warn_ctl`

## Requirements
- R1: A read with `bus_cs` high returns the warning flag on bit 7, the detect select on bit 5, the warning select on bit 4 and the interrupt enable on bit 3. Bits 6, 2, 1 and 0 always read 0, and `bus_rdata` is 0 while `bus_cs` is low.
- R2: A write (`bus_cs` and `bus_we` high) loads bits 5, 4 and 3 from `bus_wdata`. Write data on bit 7 and bits 2..0 has no effect on the register.
- R3: The comparator input passes through a two-flop synchronizer. The flag sets when the synchronized level goes from 0 (supply fine) to 1 (supply low). It becomes visible after the third rising clock edge following the input change and not before.
- R4: After a warm reset, if the synchronized supply-low level is still 1, the flag sets again on the second edge after the reset pulse.
- R5: A write with bit 6 set clears the flag when the synchronized supply-low level is 0.
- R6: A write with bit 6 set leaves the flag set while the synchronized supply-low level is 1.
- R7: When a new drop and an acknowledge write land in the same cycle, the flag ends up set.
- R8: `warn_irq` is high exactly when the flag and the interrupt enable are both 1.
- R9: A power-up reset (`rst_n` low or a `rst_power` pulse) clears the flag, the interrupt enable and both trip-point selects.
- R10: A `rst_lowv` or `rst_other` pulse clears the flag and the interrupt enable and keeps both trip-point selects.
- R11: When `rst_power` is asserted together with a warm-reset pulse, the power-up behaviour of R9 applies.
- R12: `det_trip_hi` follows bit 5 and `warn_trip_hi` follows bit 4. A value of 1 selects the high trip point and 0 the low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-up |
| rst_power | input | 1 | Power-up reset pulse, synchronous |
| rst_lowv | input | 1 | Low-voltage reset pulse, synchronous |
| rst_other | input | 1 | Any other system reset pulse, synchronous |
| supply_low_async | input | 1 | Comparator output, 1 when the supply is below the warning threshold |
| bus_cs | input | 1 | Register select |
| bus_we | input | 1 | Write enable, qualified by `bus_cs` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| det_trip_hi | output | 1 | Detect comparator trip-point select |
| warn_trip_hi | output | 1 | Warning comparator trip-point select |
| warn_irq | output | 1 | Interrupt request |

## Verification
The checker watches, on every cycle, the relations between the synchronized level, the edge event, the flag and the reset kind. These cover setting on a drop, the acknowledge clearing or being refused depending on the supply level, the field clearing of each reset kind, the interrupt equation, and the read layout with its zero bits. Only the bench scenarios show the exact latency through the synchronizer, the re-arming of the flag after a warm reset while the supply is still low, the same-cycle collision between a drop and an acknowledge, and the precedence of a power-up pulse over a simultaneous warm pulse.

// File: rtl/supply_warn_pkg.sv
// Package: shared constants and types for the supply warning register.
// Assumes an 8-bit register with fixed field positions decoded by software.
package supply_warn_pkg;

    localparam int REG_W      = 8;
    localparam int POS_FLAG   = 7;
    localparam int POS_ACK    = 6;
    localparam int POS_DETSEL = 5;
    localparam int POS_WRNSEL = 4;
    localparam int POS_IRQEN  = 3;

    // Reset kind seen in the current cycle, after priority resolution.
    typedef enum logic [1:0] {
        RST_NONE  = 2'd0,
        RST_POWER = 2'd1,
        RST_WARM  = 2'd2
    } rst_kind_e;

    // Decoded fields of one bus write.
    typedef struct packed {
        logic wr;
        logic ack;
        logic det_sel;
        logic wrn_sel;
        logic irq_en;
    } wr_fields_t;

endpackage

// File: rtl/supply_warn_sync.sv
// Module: multi-stage synchronizer for the asynchronous comparator level.
// Assumes the input is a slow level; STAGES flops in series, cleared by rst_n.
module supply_warn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_async,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din_async};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/supply_warn_rstarb.sv
// Module: resolves the reset sources into one reset kind.
// Assumes synchronous pulses; rst_n low and rst_power both mean power-up and win.
module supply_warn_rstarb
    import supply_warn_pkg::*;
(
    input  logic      rst_n,
    input  logic      rst_power,
    input  logic      rst_lowv,
    input  logic      rst_other,
    output rst_kind_e kind
);
    // Priority: power-up first, then either warm source.
    always_comb begin
        if (!rst_n || rst_power) begin
            kind = RST_POWER;
        end else if (rst_lowv || rst_other) begin
            kind = RST_WARM;
        end else begin
            kind = RST_NONE;
        end
    end
endmodule

// File: rtl/supply_warn_flag.sv
// Module: sticky warning flag with edge detection and conditional acknowledge.
// Assumes low_sync is already synchronous; a reset re-arms the edge detector
// so that a supply still low after reset sets the flag again.
module supply_warn_flag
    import supply_warn_pkg::*;
(
    input  logic      clk,
    input  logic      low_sync,
    input  rst_kind_e kind,
    input  logic      ack_req,
    output logic      rise,
    output logic      flag
);
    logic prev_q;
    logic flag_q;

    assign rise = low_sync && !prev_q;

    // Remember the last synchronized level; any reset treats it as "fine".
    always_ff @(posedge clk) begin
        if (kind != RST_NONE) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= low_sync;
        end
    end

    // Flag: reset clears, a new drop sets (winning over ack), ack clears when recovered.
    always_ff @(posedge clk) begin
        if (kind != RST_NONE) begin
            flag_q <= 1'b0;
        end else if (rise) begin
            flag_q <= 1'b1;
        end else if (ack_req && !low_sync) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/supply_warn_cfg.sv
// Module: configuration fields (trip-point selects and interrupt enable).
// Assumes selects survive warm resets and only a power-up reset clears them.
module supply_warn_cfg
    import supply_warn_pkg::*;
(
    input  logic       clk,
    input  rst_kind_e  kind,
    input  wr_fields_t wf,
    output logic       det_sel,
    output logic       wrn_sel,
    output logic       irq_en
);
    logic det_q;
    logic wrn_q;
    logic ien_q;

    // Trip-point selects: cleared only by power-up, loaded by a write otherwise.
    always_ff @(posedge clk) begin
        if (kind == RST_POWER) begin
            det_q <= 1'b0;
            wrn_q <= 1'b0;
        end else if (kind == RST_NONE && wf.wr) begin
            det_q <= wf.det_sel;
            wrn_q <= wf.wrn_sel;
        end
    end

    // Interrupt enable: cleared by every reset kind, loaded by a write.
    always_ff @(posedge clk) begin
        if (kind != RST_NONE) begin
            ien_q <= 1'b0;
        end else if (wf.wr) begin
            ien_q <= wf.irq_en;
        end
    end

    assign det_sel = det_q;
    assign wrn_sel = wrn_q;
    assign irq_en  = ien_q;
endmodule

// File: rtl/supply_warn_ctl.sv
// Module: top of the supply warning register.
// Assumes one register on a simple select/write-enable bus, combinational read data.
module supply_warn_ctl
    import supply_warn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_power,
    input  logic             rst_lowv,
    input  logic             rst_other,
    input  logic             supply_low_async,
    input  logic             bus_cs,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             det_trip_hi,
    output logic             warn_trip_hi,
    output logic             warn_irq
);
    rst_kind_e  rst_kind;
    logic       low_sync;
    logic       warn_rise;
    logic       flag_q;
    logic       ie_q;
    wr_fields_t wf;
    logic       unused_wr_bits;

    supply_warn_rstarb i_rstarb (
        .rst_n     (rst_n),
        .rst_power (rst_power),
        .rst_lowv  (rst_lowv),
        .rst_other (rst_other),
        .kind      (rst_kind)
    );

    supply_warn_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_async (supply_low_async),
        .dout      (low_sync)
    );

    // Decode a bus write into its fields; flag and reserved bits are dropped.
    always_comb begin
        wf.wr      = bus_cs && bus_we;
        wf.ack     = wf.wr && bus_wdata[POS_ACK];
        wf.det_sel = bus_wdata[POS_DETSEL];
        wf.wrn_sel = bus_wdata[POS_WRNSEL];
        wf.irq_en  = bus_wdata[POS_IRQEN];
    end
    assign unused_wr_bits = ^{bus_wdata[POS_FLAG], bus_wdata[POS_IRQEN-1:0]};

    supply_warn_flag i_flag (
        .clk      (clk),
        .low_sync (low_sync),
        .kind     (rst_kind),
        .ack_req  (wf.ack),
        .rise     (warn_rise),
        .flag     (flag_q)
    );

    supply_warn_cfg i_cfg (
        .clk     (clk),
        .kind    (rst_kind),
        .wf      (wf),
        .det_sel (det_trip_hi),
        .wrn_sel (warn_trip_hi),
        .irq_en  (ie_q)
    );

    // Assemble the read view; unselected reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_cs) begin
            bus_rdata[POS_FLAG]   = flag_q;
            bus_rdata[POS_DETSEL] = det_trip_hi;
            bus_rdata[POS_WRNSEL] = warn_trip_hi;
            bus_rdata[POS_IRQEN]  = ie_q;
        end
    end

    assign warn_irq = flag_q && ie_q;
endmodule

// File: rtl/supply_warn_chk.sv
// Module: assertion checker bound to supply_warn_ctl.
// Assumes access to the synchronized level, edge event, flag and reset kind.
module supply_warn_chk
    import supply_warn_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input rst_kind_e        rst_kind,
    input logic             low_sync,
    input logic             warn_rise,
    input logic             flag_q,
    input logic             ie_q,
    input logic             ack_req,
    input logic             bus_cs,
    input logic [REG_W-1:0] bus_rdata,
    input logic             det_trip_hi,
    input logic             warn_trip_hi,
    input logic             warn_irq
);
    // R3
    rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_rise && rst_kind == RST_NONE) |=> flag_q);

    // R3
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_rise |-> low_sync);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !low_sync && rst_kind == RST_NONE) |=> !flag_q);

    // R6
    ack_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && low_sync && rst_kind == RST_NONE) |=> flag_q);

    // R8
    irq_equation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |-> (warn_irq == (bus_rdata[7] && bus_rdata[3])));

    // R9
    power_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_kind == RST_POWER) |=> (!flag_q && !ie_q && !det_trip_hi && !warn_trip_hi));

    // R10
    warm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_kind == RST_WARM) |=> (!flag_q && !ie_q
            && det_trip_hi == $past(det_trip_hi) && warn_trip_hi == $past(warn_trip_hi)));

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |-> (bus_rdata[6] == 1'b0 && bus_rdata[2:0] == 3'b000));

    // R12
    select_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |-> (bus_rdata[5] == det_trip_hi && bus_rdata[4] == warn_trip_hi));
endmodule

bind supply_warn_ctl supply_warn_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_kind     (rst_kind),
    .low_sync     (low_sync),
    .warn_rise    (warn_rise),
    .flag_q       (flag_q),
    .ie_q         (ie_q),
    .ack_req      (wf.ack),
    .bus_cs       (bus_cs),
    .bus_rdata    (bus_rdata),
    .det_trip_hi  (det_trip_hi),
    .warn_trip_hi (warn_trip_hi),
    .warn_irq     (warn_irq)
);

// File: tb/test_supply_warn_ctl.sv
// Directed bench for supply_warn_ctl: one task per scenario, each checking itself.
module test_supply_warn_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_power = 1'b0;
    logic       rst_lowv = 1'b0;
    logic       rst_other = 1'b0;
    logic       supply_low_async = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       det_trip_hi;
    logic       warn_trip_hi;
    logic       warn_irq;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    supply_warn_ctl i_supply_warn_ctl (
        .clk              (clk),
        .rst_n            (rst_n),
        .rst_power        (rst_power),
        .rst_lowv         (rst_lowv),
        .rst_other        (rst_other),
        .supply_low_async (supply_low_async),
        .bus_cs           (bus_cs),
        .bus_we           (bus_we),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .det_trip_hi      (det_trip_hi),
        .warn_trip_hi     (warn_trip_hi),
        .warn_irq         (warn_irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b1; bus_wdata = d;
        tick();
        bus_cs = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic check_read(input logic [7:0] exp, input string req);
        logic [7:0] got;
        bus_cs = 1'b1; bus_we = 1'b0;
        #1;
        got = bus_rdata;
        bus_cs = 1'b0;
        check(got == exp, req, got, exp);
    endtask

    task automatic set_low(input logic v);
        supply_low_async = v;
        repeat (4) tick();
    endtask

    task automatic t_reset_state();
        check_read(8'h00, "R9 reset state");
        check({det_trip_hi, warn_trip_hi, warn_irq} == 3'b000, "R9 outputs",
              {det_trip_hi, warn_trip_hi, warn_irq}, 0);
        bus_cs = 1'b0; #1;
        check(bus_rdata == 8'h00, "R1 unselected read", bus_rdata, 0);
    endtask

    task automatic t_config();
        bus_write(8'hFF);
        check_read(8'h38, "R2 R1 write all ones");
        check({det_trip_hi, warn_trip_hi} == 2'b11, "R12 selects high",
              {det_trip_hi, warn_trip_hi}, 3);
        check(warn_irq == 1'b0, "R8 no flag no irq", warn_irq, 0);
        bus_write(8'h10);
        check({det_trip_hi, warn_trip_hi} == 2'b01, "R12 warn only",
              {det_trip_hi, warn_trip_hi}, 1);
        bus_write(8'h38);
    endtask

    task automatic t_flag_timing();
        supply_low_async = 1'b1;
        tick(); tick();
        check_read(8'h38, "R3 not yet after two edges");
        tick();
        check_read(8'hB8, "R3 set on third edge");
        check(warn_irq == 1'b1, "R8 irq with enable", warn_irq, 1);
    endtask

    task automatic t_ack_refused();
        bus_write(8'h78);
        tick();
        check_read(8'hB8, "R6 ack while low");
    endtask

    task automatic t_ack_clears();
        set_low(1'b0);
        check_read(8'hB8, "R3 flag sticky after recovery");
        bus_write(8'h78);
        check_read(8'h38, "R5 ack after recovery");
        check(warn_irq == 1'b0, "R8 irq drops", warn_irq, 0);
        bus_write(8'h30);
        set_low(1'b1);
        check_read(8'hB0, "R8 flag set");
        check(warn_irq == 1'b0, "R8 polled, no irq", warn_irq, 0);
        set_low(1'b0);
        bus_write(8'h78);
    endtask

    task automatic t_collision();
        supply_low_async = 1'b1;
        tick(); tick();
        bus_write(8'h78);
        check_read(8'hB8, "R7 drop wins over ack");
    endtask

    task automatic t_warm_low();
        rst_lowv = 1'b1;
        tick();
        rst_lowv = 1'b0;
        check_read(8'h30, "R10 lowv clears flag and enable");
        tick();
        check_read(8'hB0, "R4 re-set after warm reset");
    endtask

    task automatic t_warm_high();
        set_low(1'b0);
        bus_write(8'h68);
        bus_write(8'h28);
        rst_other = 1'b1;
        tick();
        rst_other = 1'b0;
        tick();
        check_read(8'h20, "R10 other reset keeps selects");
        check({det_trip_hi, warn_trip_hi} == 2'b10, "R10 select pins",
              {det_trip_hi, warn_trip_hi}, 2);
    endtask

    task automatic t_power_prio();
        bus_write(8'h38);
        rst_power = 1'b1; rst_lowv = 1'b1;
        tick();
        rst_power = 1'b0; rst_lowv = 1'b0;
        check_read(8'h00, "R11 power wins over lowv");
        bus_write(8'h38);
        rst_power = 1'b1;
        tick();
        rst_power = 1'b0;
        check_read(8'h00, "R9 power pulse clears all");
        bus_write(8'hC7);
        check_read(8'h00, "R2 flag and reserved writes ignored");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset_state();
        t_config();
        t_flag_timing();
        t_ack_refused();
        t_ack_clears();
        t_collision();
        t_warm_low();
        t_warm_high();
        t_power_prio();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule